// File: doc/BRIEF.md
# Escalating Watchdog Controller with Unlock Gate

The block turns expiry pulses from an external timer into a graded series of alarms. Software picks one of several timer channels, sets how many timer periods make one watchdog period, and decides which alarm outputs may fire. Once started, the watchdog counts its own periods. At the first expiration it raises a local interrupt. Further expirations raise a fast interrupt, then a remote interrupt, then a debug reset. The fifth expiration raises the power-on system reset. The three interrupt outputs also depend on this watchdog's bit in a shared interrupt-enable register.

Stopping the watchdog is guarded. A key value must first be written to the unlock register. A disable command given without that key has no effect. An accepted disable stops the watchdog, clears the expiration count and drops every output. It also uses up the key, so the next disable needs a new unlock. To service the watchdog, software unlocks it, disables it and starts it again. A start command on a running watchdog also restarts the count from zero.

Top module: `wdog_esc`

## Requirements
- R1: After reset all five alarm outputs are low, the watchdog is stopped and locked, and every register reads as zero.
- R2: Register address 0 holds a 17-bit configuration word and reads back as written, zero-extended. Bits [3:0] select the timer channel. Bits [11:4] hold the timer periods per watchdog period. Bits 12 to 16 enable, in order, the local interrupt, the fast interrupt, the remote interrupt, the debug reset and the power-on reset.
- R3: Only pulses on the selected channel are counted. A channel number at or above the channel count selects nothing.
- R4: With a period field of P, one expiration occurs on every P-th counted pulse. A period of 0 acts as 1.
- R5: Outputs escalate in a fixed order. Expiration k (1 to 5) asserts the local interrupt, fast interrupt, remote interrupt, debug reset or power-on reset respectively, and only if that output's enable bit is set. Asserted outputs stay high, and the count saturates at 5.
- R6: The three interrupt outputs also need bit 16 + 4 × WDOG_IDX of the shared enable register (address 3). The two reset outputs ignore that bit.
- R7: Writing 0x0000C45A to address 2 arms the unlock. Any other value written there disarms it. Address 2 reads 1 while armed.
- R8: Writing a 1 to bit 1 of address 1 while armed stops the watchdog. It clears the count, drops all outputs and disarms the unlock. Address 1 reads 1 while running.
- R9: A disable written while disarmed is ignored. The watchdog keeps running and keeps its count.
- R10: Writing a 1 to bit 0 of address 1 starts the watchdog with a zero count. If it is already running, the count restarts from zero.
- R11: While stopped, timer pulses change nothing.
- R12: If a command write sets both bits, an armed watchdog treats it as a disable. A disarmed watchdog treats it as a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 config, 1 command, 2 unlock, 3 shared enable) |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, combinational |
| tmrExpire | input | NUM_CH | One-cycle expiry pulses, one per timer channel |
| irqLocal | output | 1 | Local interrupt (first expiration) |
| irqFast | output | 1 | Fast interrupt (second expiration) |
| irqRemote | output | 1 | Remote interrupt (third expiration) |
| rstDebug | output | 1 | Debug reset (fourth expiration) |
| rstPor | output | 1 | Power-on system reset (fifth expiration) |

## Verification
The assertions assume that the timer delivers each expiry as a single-cycle pulse. They also assume that a register write lasts one cycle and carries stable address and data. Under those conditions, a held pulse or write cannot count twice. The stimulus drives every write and every pulse for exactly one cycle, changing them on the falling clock edge. It also keeps the period field small, so that each escalation step is reached in a few pulses.

// File: rtl/wdog_esc_pkg.sv
package wdog_esc_pkg;
  localparam int ADDR_W    = 2;
  localparam int DATA_W    = 32;
  localparam int NUM_LVL   = 5;
  localparam int CNT_W     = 3;
  localparam int CH_W      = 4;
  localparam int PER_W     = 8;
  localparam int PER_LSB   = CH_W;
  localparam int EN_LSB    = PER_LSB + PER_W;
  localparam int CFG_W     = EN_LSB + NUM_LVL;
  localparam int NUM_IRQ   = 3;

  localparam logic [ADDR_W-1:0] A_CFG    = 2'd0;
  localparam logic [ADDR_W-1:0] A_CMD    = 2'd1;
  localparam logic [ADDR_W-1:0] A_UNLOCK = 2'd2;
  localparam logic [ADDR_W-1:0] A_MASK   = 2'd3;

  localparam int CMD_START = 0;
  localparam int CMD_STOP  = 1;

  typedef struct packed {
    logic clearCnt;
    logic countEn;
  } ctrl2dp_t;
endpackage

// File: rtl/wdog_esc_ctrl.sv
module wdog_esc_ctrl
  import wdog_esc_pkg::*;
#(
  parameter int WDOG_IDX = 0,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h0000C45A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic [CFG_W-1:0]  cfgWord,
  output logic              maskBit,
  output logic              isRunning,
  output logic              isUnlocked,
  output ctrl2dp_t          strobes
);
  localparam int MASK_BIT = 16 + 4 * WDOG_IDX;

  logic [CFG_W-1:0]  cfgReg;
  logic [DATA_W-1:0] maskReg;
  logic              runReg;
  logic              unlockReg;

  logic cmdWr, stopOk, startReq, keyWr, cfgWr, maskWr;

  always_comb begin
    cmdWr    = regWrEn && (regAddr == A_CMD);
    keyWr    = regWrEn && (regAddr == A_UNLOCK);
    cfgWr    = regWrEn && (regAddr == A_CFG);
    maskWr   = regWrEn && (regAddr == A_MASK);
    stopOk   = cmdWr && regWrData[CMD_STOP] && unlockReg;
    startReq = cmdWr && regWrData[CMD_START] && !stopOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg    <= '0;
      maskReg   <= '0;
      runReg    <= 1'b0;
      unlockReg <= 1'b0;
    end else begin
      if (cfgWr)  cfgReg  <= regWrData[CFG_W-1:0];
      if (maskWr) maskReg <= regWrData;
      if (stopOk)        runReg <= 1'b0;
      else if (startReq) runReg <= 1'b1;
      if (keyWr)       unlockReg <= (regWrData == UNLOCK_KEY);
      else if (stopOk) unlockReg <= 1'b0;
    end
  end

  always_comb begin
    unique case (regAddr)
      A_CFG:    regRdData = {{(DATA_W-CFG_W){1'b0}}, cfgReg};
      A_CMD:    regRdData = {{(DATA_W-1){1'b0}}, runReg};
      A_UNLOCK: regRdData = {{(DATA_W-1){1'b0}}, unlockReg};
      default:  regRdData = maskReg;
    endcase
  end

  assign strobes.clearCnt = stopOk || startReq;
  assign strobes.countEn  = runReg;
  assign cfgWord    = cfgReg;
  assign maskBit    = maskReg[MASK_BIT];
  assign isRunning  = runReg;
  assign isUnlocked = unlockReg;
endmodule

// File: rtl/wdog_esc_dp.sv
module wdog_esc_dp
  import wdog_esc_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl2dp_t          strobes,
  input  logic [CFG_W-1:0]  cfgWord,
  input  logic              maskBit,
  input  logic [NUM_CH-1:0] tmrExpire,
  output logic [CNT_W-1:0]  expCount,
  output logic [NUM_LVL-1:0] escVec
);
  logic [CH_W-1:0]    chSel;
  logic [PER_W-1:0]   perField, perLast;
  logic [NUM_LVL-1:0] enBits;
  logic [NUM_CH-1:0]  hit;
  logic               tick;
  logic [PER_W-1:0]   subCnt;

  assign chSel    = cfgWord[PER_LSB-1:0];
  assign perField = cfgWord[EN_LSB-1:PER_LSB];
  assign enBits   = cfgWord[CFG_W-1:EN_LSB];
  assign perLast  = (perField == '0) ? '0 : perField - 1'b1;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chSel
    assign hit[ch] = tmrExpire[ch] && (chSel == CH_W'(ch));
  end
  assign tick = |hit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subCnt   <= '0;
      expCount <= '0;
    end else if (strobes.clearCnt) begin
      subCnt   <= '0;
      expCount <= '0;
    end else if (strobes.countEn && tick) begin
      if (subCnt >= perLast) begin
        subCnt <= '0;
        if (expCount < CNT_W'(NUM_LVL)) expCount <= expCount + 1'b1;
      end else begin
        subCnt <= subCnt + 1'b1;
      end
    end
  end

  for (genvar k = 0; k < NUM_LVL; k++) begin : g_esc
    if (k < NUM_IRQ) begin : g_irq
      assign escVec[k] = (expCount > CNT_W'(k)) && enBits[k] && maskBit;
    end else begin : g_rst
      assign escVec[k] = (expCount > CNT_W'(k)) && enBits[k];
    end
  end
endmodule

// File: rtl/wdog_esc.sv
module wdog_esc
  import wdog_esc_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int WDOG_IDX = 0,
  parameter logic [31:0] UNLOCK_KEY = 32'h0000C45A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [NUM_CH-1:0] tmrExpire,
  output logic              irqLocal,
  output logic              irqFast,
  output logic              irqRemote,
  output logic              rstDebug,
  output logic              rstPor
);
  ctrl2dp_t           strobes;
  logic [CFG_W-1:0]   cfgWord;
  logic               maskBit, isRunning, isUnlocked;
  logic [CNT_W-1:0]   expCount;
  logic [NUM_LVL-1:0] escVec;

  wdog_esc_ctrl #(.WDOG_IDX(WDOG_IDX), .UNLOCK_KEY(UNLOCK_KEY)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .cfgWord(cfgWord),
    .maskBit(maskBit), .isRunning(isRunning), .isUnlocked(isUnlocked),
    .strobes(strobes)
  );

  wdog_esc_dp #(.NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cfgWord(cfgWord),
    .maskBit(maskBit), .tmrExpire(tmrExpire), .expCount(expCount),
    .escVec(escVec)
  );

  assign irqLocal  = escVec[0];
  assign irqFast   = escVec[1];
  assign irqRemote = escVec[2];
  assign rstDebug  = escVec[3];
  assign rstPor    = escVec[4];
endmodule

// File: rtl/wdog_esc_chk.sv
module wdog_esc_chk #(
  parameter logic [31:0] UNLOCK_KEY = 32'h0000C45A
) (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic [1:0]  regAddr,
  input logic [31:0] regWrData,
  input logic        isRunning,
  input logic        isUnlocked,
  input logic        maskBit,
  input logic [2:0]  expCount,
  input logic [4:0]  escVec
);
  p_unlock_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd2) |=> (isUnlocked == ($past(regWrData) == UNLOCK_KEY)));

  p_disable_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd1 && regWrData[1] && isUnlocked)
      |=> (!isRunning && !isUnlocked && escVec == 5'd0));

  p_locked_stop_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd1 && regWrData[1] && !regWrData[0] && !isUnlocked)
      |=> $stable(isRunning));

  p_start_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd1 && regWrData[0] && !regWrData[1])
      |=> (isRunning && expCount == 3'd0));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !isRunning |-> (expCount == 3'd0 && escVec == 5'd0));

  p_single_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    isRunning |=> ({1'b0, expCount} <= {1'b0, $past(expCount)} + 4'd1));

  p_saturate_r5: assert property (@(posedge clk) disable iff (!rstN)
    expCount <= 3'd5);

  p_irq_mask_r6: assert property (@(posedge clk) disable iff (!rstN)
    (escVec[0] || escVec[1] || escVec[2]) |-> maskBit);
endmodule

bind wdog_esc wdog_esc_chk #(.UNLOCK_KEY(UNLOCK_KEY)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .isRunning(isRunning), .isUnlocked(isUnlocked),
  .maskBit(maskBit), .expCount(expCount), .escVec(escVec)
);

// File: tb/wdog_esc_tb.sv
module wdog_esc_tb;
  localparam int NCH = 8;
  localparam int IDX = 1;
  localparam logic [31:0] KEY = 32'h0000C45A;
  localparam logic [31:0] MASK_ON = 32'h1 << (16 + 4 * IDX);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [31:0] regWrData = 32'd0;
  logic [31:0] regRdData;
  logic [NCH-1:0] tmrExpire = '0;
  logic irqLocal, irqFast, irqRemote, rstDebug, rstPor;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  wdog_esc #(.NUM_CH(NCH), .WDOG_IDX(IDX)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .tmrExpire(tmrExpire),
    .irqLocal(irqLocal), .irqFast(irqFast), .irqRemote(irqRemote),
    .rstDebug(rstDebug), .rstPor(rstPor)
  );

  function automatic logic [4:0] outs();
    return {rstPor, rstDebug, irqRemote, irqFast, irqLocal};
  endfunction

  function automatic logic [4:0] expOut(int lvl, logic [4:0] en, logic m);
    logic [4:0] v;
    for (int k = 0; k < 5; k++) v[k] = (lvl > k) && en[k] && ((k < 3) ? m : 1'b1);
    return v;
  endfunction

  function automatic logic [31:0] cfgW(int ch, int per, logic [4:0] en);
    return {15'd0, en, 8'(per), 4'(ch)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic pulse(int ch);
    @(negedge clk);
    tmrExpire = '0;
    tmrExpire[ch] = 1'b1;
    @(negedge clk);
    tmrExpire = '0;
  endtask

  task automatic stopWd();
    wr(2'd2, KEY);
    wr(2'd1, 32'd2);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 outputs", 32'(outs()), 32'd0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check("R1 register", d, 32'd0);
    end
  endtask

  task automatic t_config();
    logic [31:0] d;
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d);
    check("R2 readback all ones", d, 32'h0001_FFFF);
    wr(2'd0, cfgW(5, 9, 5'b10110));
    rd(2'd0, d);
    check("R2 readback fields", d, cfgW(5, 9, 5'b10110));
  endtask

  task automatic t_escalate();
    wr(2'd3, MASK_ON);
    wr(2'd0, cfgW(2, 1, 5'b11111));
    wr(2'd1, 32'd1);
    for (int n = 1; n <= 5; n++) begin
      pulse(3);
      check("R3 other channel", 32'(outs()), 32'(expOut(n - 1, 5'b11111, 1'b1)));
      pulse(2);
      check("R5 level", 32'(outs()), 32'(expOut(n, 5'b11111, 1'b1)));
    end
    pulse(2);
    check("R5 saturate", 32'(outs()), 32'h1F);
    stopWd();
  endtask

  task automatic t_badChannel();
    wr(2'd0, cfgW(9, 1, 5'b11111));
    wr(2'd1, 32'd1);
    for (int c = 0; c < NCH; c++) pulse(c);
    check("R3 out of range channel", 32'(outs()), 32'd0);
    stopWd();
  endtask

  task automatic t_period();
    wr(2'd0, cfgW(1, 3, 5'b11111));
    wr(2'd1, 32'd1);
    pulse(1); pulse(1);
    check("R4 before period end", 32'(outs()), 32'd0);
    pulse(1);
    check("R4 period 3 first", 32'(outs()), 32'(expOut(1, 5'b11111, 1'b1)));
    pulse(1); pulse(1); pulse(1);
    check("R4 period 3 second", 32'(outs()), 32'(expOut(2, 5'b11111, 1'b1)));
    stopWd();
    wr(2'd0, cfgW(1, 0, 5'b11111));
    wr(2'd1, 32'd1);
    pulse(1);
    check("R4 period 0 acts as 1", 32'(outs()), 32'(expOut(1, 5'b11111, 1'b1)));
    stopWd();
  endtask

  task automatic t_gating();
    wr(2'd0, cfgW(0, 1, 5'b10000));
    wr(2'd1, 32'd1);
    for (int n = 1; n <= 4; n++) pulse(0);
    check("R5 disabled levels silent", 32'(outs()), 32'd0);
    pulse(0);
    check("R5 por only", 32'(outs()), 32'h10);
    stopWd();
    wr(2'd3, 32'hFFFF_FFFF ^ MASK_ON);
    wr(2'd0, cfgW(0, 1, 5'b11111));
    wr(2'd1, 32'd1);
    for (int n = 1; n <= 4; n++) pulse(0);
    check("R6 mask off, resets still fire", 32'(outs()), 32'(expOut(4, 5'b11111, 1'b0)));
    wr(2'd3, MASK_ON);
    check("R6 mask on shows irqs", 32'(outs()), 32'(expOut(4, 5'b11111, 1'b1)));
    stopWd();
  endtask

  task automatic t_unlock();
    logic [31:0] d;
    wr(2'd0, cfgW(0, 1, 5'b11111));
    wr(2'd1, 32'd1);
    pulse(0); pulse(0);
    wr(2'd1, 32'd2);
    rd(2'd1, d);
    check("R9 still running", d, 32'd1);
    check("R9 count kept", 32'(outs()), 32'(expOut(2, 5'b11111, 1'b1)));
    wr(2'd2, KEY ^ 32'h1);
    rd(2'd2, d);
    check("R7 wrong key", d, 32'd0);
    wr(2'd2, KEY);
    rd(2'd2, d);
    check("R7 armed", d, 32'd1);
    wr(2'd2, 32'd0);
    wr(2'd1, 32'd2);
    rd(2'd1, d);
    check("R7 disarmed by other value", d, 32'd1);
    stopWd();
    rd(2'd1, d);
    check("R8 stopped", d, 32'd0);
    rd(2'd2, d);
    check("R8 disarmed", d, 32'd0);
    check("R8 outputs low", 32'(outs()), 32'd0);
    pulse(0); pulse(0);
    check("R11 stopped ignores pulses", 32'(outs()), 32'd0);
    wr(2'd1, 32'd1);
    wr(2'd1, 32'd2);
    rd(2'd1, d);
    check("R8 key used up", d, 32'd1);
    stopWd();
  endtask

  task automatic t_restart();
    wr(2'd0, cfgW(4, 1, 5'b11111));
    wr(2'd1, 32'd1);
    pulse(4); pulse(4); pulse(4);
    wr(2'd1, 32'd1);
    check("R10 restart clears", 32'(outs()), 32'd0);
    pulse(4);
    check("R10 counts from zero", 32'(outs()), 32'(expOut(1, 5'b11111, 1'b1)));
    stopWd();
  endtask

  task automatic t_both();
    logic [31:0] d;
    wr(2'd1, 32'd3);
    rd(2'd1, d);
    check("R12 both bits locked starts", d, 32'd1);
    wr(2'd2, KEY);
    wr(2'd1, 32'd3);
    rd(2'd1, d);
    check("R12 both bits armed stops", d, 32'd0);
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_config();
    t_escalate();
    t_badChannel();
    t_period();
    t_gating();
    t_unlock();
    t_restart();
    t_both();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule